// File: doc/BRIEF.md
# Trace Packet Word Packer

The packer sits between a trace packet source and a fixed-width trace memory. Each cycle the source may offer one packet of 0 to `WORD_W` bits, with its length on a separate port. The packer appends the packet bits to an internal bit accumulator. Whenever the accumulator holds at least one full word, it emits that word with a one-cycle write strobe and keeps the leftover bits for the next word.

When tracing ends, a flush request drains the accumulator. One extra cycle writes the partial word out, with the unused upper bits set to zero. During that cycle the busy output is high. A source that sees busy high keeps its packet on the inputs until busy falls.

A build option chooses whether packet bits above the stated length are masked inside the block or are assumed to be zero already.

Top module: `trace_word_packer`

## Requirements
- R1: A packet is taken in any cycle where `pkt_valid` is high and `busy` is low. Its bits are appended least-significant bit first. Earlier bits land at lower bit positions of the output word: bit 0 of the first packet goes to `mem_word[0]`.
- R2: The cycle after a packet is taken that brings the held bit count to `WORD_W` or more, `mem_we` is high for one cycle. `mem_word` then carries the lowest `WORD_W` held bits, and the remaining bits are kept in order for the next word.
- R3: At most one word is written per cycle, and the held bit count after any cycle is always below `WORD_W`, so no bit is ever lost.
- R4: A `flush_req` sampled while `busy` is low raises `busy` for exactly one cycle. At the end of that cycle, if any bits are held, `mem_we` pulses with those bits in the low positions and zeros above.
- R5: A flush with no bits held produces no write.
- R6: A packet presented while `busy` is high is not taken. After the flush the accumulator is empty, and the next taken packet starts a fresh word at bit 0.
- R7: With masking enabled (the default), `pkt_data` bits at positions at or above `pkt_len` are ignored.
- R8: After reset, `mem_we` and `busy` are low and the accumulator is empty.
- R9: A packet taken in the same cycle as a flush request is included in the flushed word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | Packet offered this cycle |
| pkt_data | input | WORD_W | Packet bits, LSB first |
| pkt_len | input | $clog2(WORD_W+1) | Number of valid packet bits, 0 to WORD_W |
| flush_req | input | 1 | Request to drain the partial word |
| mem_we | output | 1 | Trace memory write strobe |
| mem_word | output | WORD_W | Word to write |
| busy | output | 1 | Flush cycle in progress; packets are held |

## Verification
The bench builds the block with `WORD_W = 8` and masking on. At that width, random lengths from 0 to 8 often cross word boundaries, often fill a word exactly, and leave carry-over bits of every count from 0 to 7. Random flushes therefore land at every partial fill level. Garbage in the data bits above the length checks the masking. Directed sequences cover a flush with nothing held, a flush in the same cycle as a packet, and a packet offered while busy.

// File: rtl/trace_pack_pkg.sv
package trace_pack_pkg;
   // bits needed to hold a value from 0 to n inclusive
   function automatic int range_bits(input int n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/pkt_len_mask.sv
module pkt_len_mask #(
   parameter int WORD_W  = 32,
   parameter int LEN_W   = 6,
   parameter bit MASK_EN = 1'b1
) (
   input  logic [WORD_W-1:0] raw_data,
   input  logic [LEN_W-1:0]  raw_len,
   output logic [WORD_W-1:0] clean_data
);
   generate
      if (MASK_EN) begin : g_mask
         logic [WORD_W-1:0] keep;
         // shift by WORD_W yields zero, so keep becomes all ones
         assign keep       = ~({WORD_W{1'b1}} << raw_len);
         assign clean_data = raw_data & keep;
      end else begin : g_pass
         logic unused_len;
         assign unused_len = ^raw_len;
         assign clean_data = raw_data;
      end
   endgenerate
endmodule

// File: rtl/pkt_bit_accum.sv
module pkt_bit_accum #(
   parameter int WORD_W = 32,
   parameter int LEN_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [WORD_W-1:0] in_data,
   input  logic [LEN_W-1:0]  in_len,
   input  logic              flush_req,
   output logic              mem_we,
   output logic [WORD_W-1:0] mem_word,
   output logic              busy
);
   localparam int ACC_W = 2 * WORD_W;
   localparam int CNT_W = $clog2(ACC_W);
   localparam logic [CNT_W-1:0] WORD_CNT = CNT_W'(WORD_W);

   logic [ACC_W-1:0] acc_q;
   logic [CNT_W-1:0] cnt_q;
   logic             busy_q, we_q;
   logic [WORD_W-1:0] word_q;

   logic [ACC_W-1:0] acc_next;
   logic [CNT_W-1:0] cnt_sum;

   always_comb begin
      acc_next = acc_q;
      cnt_sum  = cnt_q;
      if (take) begin
         acc_next = acc_q | ({{WORD_W{1'b0}}, in_data} << cnt_q);
         cnt_sum  = cnt_q + CNT_W'(in_len);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
         we_q   <= 1'b0;
         word_q <= '0;
      end else if (busy_q) begin
         // drain cycle: upper bits of acc_q are zero by invariant
         we_q   <= (cnt_q != '0);
         word_q <= acc_q[WORD_W-1:0];
         acc_q  <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else begin
         busy_q <= flush_req;
         if (cnt_sum >= WORD_CNT) begin
            we_q   <= 1'b1;
            word_q <= acc_next[WORD_W-1:0];
            acc_q  <= acc_next >> WORD_W;
            cnt_q  <= cnt_sum - WORD_CNT;
         end else begin
            we_q   <= 1'b0;
            acc_q  <= acc_next;
            cnt_q  <= cnt_sum;
         end
      end
   end

   assign mem_we   = we_q;
   assign mem_word = word_q;
   assign busy     = busy_q;

   // R3: held count never reaches a full word after an edge
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < WORD_CNT);
   // R4: drain lasts exactly one cycle
   p_busy_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> !busy_q);
   // R4: a drain with held bits writes them
   p_flush_writes_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cnt_q != '0) |=> mem_we);
   // R5: a drain with nothing held writes nothing
   p_empty_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cnt_q == '0) |=> !mem_we);
   // R6: nothing is taken while draining, so the drain leaves the accumulator empty
   p_hold_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> (cnt_q == '0));
endmodule

// File: rtl/trace_word_packer.sv
module trace_word_packer
   import trace_pack_pkg::*;
#(
   parameter int WORD_W  = 32,
   parameter bit MASK_EN = 1'b1,
   localparam int LEN_W  = range_bits(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pkt_valid,
   input  logic [WORD_W-1:0] pkt_data,
   input  logic [LEN_W-1:0]  pkt_len,
   input  logic              flush_req,
   output logic              mem_we,
   output logic [WORD_W-1:0] mem_word,
   output logic              busy
);
   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("trace_word_packer: WORD_W must be at least 2");
      end
   endgenerate

   logic [WORD_W-1:0] clean_data;
   logic              take;

   assign take = pkt_valid && !busy;

   pkt_len_mask #(.WORD_W(WORD_W), .LEN_W(LEN_W), .MASK_EN(MASK_EN)) u_mask (
      .raw_data   (pkt_data),
      .raw_len    (pkt_len),
      .clean_data (clean_data)
   );

   pkt_bit_accum #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_accum (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (take),
      .in_data   (clean_data),
      .in_len    (pkt_len),
      .flush_req (flush_req),
      .mem_we    (mem_we),
      .mem_word  (mem_word),
      .busy      (busy)
   );

   // R1: length never exceeds the word width while a packet is offered
   p_len_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid |-> (int'(pkt_len) <= WORD_W));
endmodule

// File: tb/tb_trace_word_packer.sv
module tb_trace_word_packer;
   localparam int W = 8;
   localparam int LW = $clog2(W + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pkt_valid = 1'b0;
   logic [W-1:0]  pkt_data = '0;
   logic [LW-1:0] pkt_len = '0;
   logic          flush_req = 1'b0;
   logic          mem_we;
   logic [W-1:0]  mem_word;
   logic          busy;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [2*W-1:0] m_acc = '0;
   int             m_cnt = 0;
   bit             m_busy = 1'b0;

   always #4 clk = ~clk;

   trace_word_packer #(.WORD_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
      .pkt_len(pkt_len), .flush_req(flush_req), .mem_we(mem_we),
      .mem_word(mem_word), .busy(busy)
   );

   function automatic logic [W-1:0] keep_low(input logic [W-1:0] d, input int len);
      logic [W-1:0] m;
      m = (len >= W) ? {W{1'b1}} : W'((1 << len) - 1);
      return d & m;
   endfunction

   task automatic check(input string tag, input bit ok, input logic [31:0] act,
                        input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one cycle: drive, update model, compare after the edge
   task automatic step(input bit v, input logic [W-1:0] d, input int len,
                       input bit f, input string tag);
      bit            e_we;
      logic [W-1:0]  e_word;
      @(negedge clk);
      pkt_valid = v; pkt_data = d; pkt_len = LW'(len); flush_req = f;
      e_we = 1'b0; e_word = '0;
      if (m_busy) begin
         e_we = (m_cnt != 0);
         e_word = m_acc[W-1:0];
         m_acc = '0; m_cnt = 0; m_busy = 1'b0;
      end else begin
         if (v) begin
            m_acc = m_acc | ({{W{1'b0}}, keep_low(d, len)} << m_cnt);
            m_cnt = m_cnt + len;
         end
         if (m_cnt >= W) begin
            e_we = 1'b1;
            e_word = m_acc[W-1:0];
            m_acc = m_acc >> W;
            m_cnt = m_cnt - W;
         end
         m_busy = f;
      end
      @(posedge clk);
      #1;
      check({tag, " we"}, mem_we === e_we, 32'(mem_we), 32'(e_we));
      check({tag, " busy"}, busy === m_busy, 32'(busy), 32'(m_busy));
      if (e_we)
         check({tag, " word"}, mem_word === e_word, 32'(mem_word), 32'(e_word));
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      #20;
      check("R8 reset we", mem_we === 1'b0, 32'(mem_we), 0);
      check("R8 reset busy", busy === 1'b0, 32'(busy), 0);
      @(negedge clk); rst_n = 1'b1;
      // R8: empty after reset, a flush writes nothing
      step(0, '0, 0, 1, "R8 empty flush req");
      step(0, '0, 0, 0, "R5 empty flush");
      // R1 / R2: ordering, exact fill
      step(1, 8'h05, 3, 0, "R1 first");
      step(1, 8'h1F, 5, 0, "R1 R2 fill");
      step(1, 8'hA5, 8, 0, "R2 full packet");
      // R2 carry-over
      step(1, 8'h3F, 6, 0, "R2 part");
      step(1, 8'h0F, 4, 0, "R2 carry");
      // R7 garbage above length
      step(1, 8'hFE, 1, 0, "R7 mask");
      step(1, 8'h00, 0, 0, "R1 zero len");
      // R4 flush partial, R6 held packet during busy
      step(0, '0, 0, 1, "R4 flush req");
      step(1, 8'hFF, 8, 0, "R6 held while busy R4 pad");
      step(1, 8'h01, 1, 0, "R6 fresh word");
      // R9 packet with flush
      step(1, 8'h02, 2, 1, "R9 same cycle");
      step(0, '0, 0, 0, "R9 flushed");
      // random
      for (int i = 0; i < 4000; i++) begin
         int ln;
         ln = $urandom_range(W, 0);
         step(($urandom_range(3, 0) != 0), W'($urandom), ln,
              ($urandom_range(15, 0) == 0), "R1 R2 R3 R4 R7 random");
      end
      step(0, '0, 0, 1, "R4 final flush");
      step(0, '0, 0, 0, "R4 final drain");
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule